// File: doc/BRIEF.md
# Function Configuration Header Responder

This block is the configuration-space target that sits inside one device function on a shared peripheral bus. An upstream configuration port issues dword-addressed reads and writes with four byte enables. The block holds the standard 64-byte header and answers every access to the function's 256-byte configuration window. That header carries the fixed identity of the function, its command and status words, the cache-line and latency bytes, and one 32-bit memory base register.

The function comes out of reset inactive. It claims no memory or I/O range and keeps interrupt reporting switched off, so it can only be reached through configuration accesses. Enumeration software reads the identity words, probes the base register by writing all ones and reading the result back, programs a base address, and then sets command bits. The block exports those bits as decode-enable outputs, and the function's memory, I/O and interrupt logic is gated by them.

Top module: `cfg_hdr_target`

## Requirements
- R1: After reset, io_en, mem_en and irq_en are 0. The command word (dword 1, bits 15:0) reads 0x0400, the status error bits read 0, and the base register (dword 4) reads 0.
- R2: A read request (cfg_req=1, cfg_we=0) raises cfg_rvalid for exactly one cycle, in the cycle after the request, with the data in cfg_rdata. A write never raises cfg_rvalid.
- R3: Dword 0 reads {DEVICE_ID[31:16], VENDOR_ID[15:0]}, dword 2 reads {CLASS_CODE[31:8], REVISION[7:0]}, and dword 3 bits 23:16 read HDR_TYPE (default 0, ordinary device) with bits 31:24 reading 0. Writes to these fields are ignored.
- R4: Command bit 0 drives io_en, bit 1 drives mem_en, and bit 10 set disables interrupt reporting (irq_en = not bit 10). All other command bits read 0.
- R5: A write changes only the bytes whose cfg_be bit is set. In dword 1, bytes 0 and 1 form the command word and bytes 2 and 3 form the status word.
- R6: Status bits 15:11 (dword bits 31:27) are sticky error flags. Flag i is set by err_evt[i] and cleared only by writing a 1 to it with cfg_be[3] set. Writing 0 leaves it unchanged, and a set in the same cycle as a clear wins.
- R7: Status bit 3 (dword bit 19) reads the live level of int_pending. All other status bits read 0.
- R8: The base register at dword 4 has writable bits 31:BAR_LOG2 (default 31:12) and low bits that always read 0. Writing all ones reads back 0xFFFFF000, and mem_base outputs the register value.
- R9: Dword 3 byte 0 (cache line size) and byte 1 (latency timer) are read/write.
- R10: Dwords 5 to 63 (byte offsets 0x14 to 0xFF) read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Configuration access request, one cycle per access |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 6 | Dword index within the 256-byte window |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| err_evt | input | 5 | Error event pulses that set status flags 15:11 |
| int_pending | input | 1 | Function's interrupt-pending level, shown in status bit 3 |
| io_en | output | 1 | I/O space decode enable |
| mem_en | output | 1 | Memory space decode enable |
| irq_en | output | 1 | Interrupt reporting enable |
| mem_base | output | 32 | Programmed memory base address |

## Verification
The checker watches the one-cycle read response, the fixed identity word, zeros for the base register's low bits and for the region above the header, and that the decode and interrupt enables change only when the matching command byte is written. On every cycle it also checks that error flags, once set, stay set until a clearing write to the top status byte. Only the bench's scenarios can show the values themselves. Those are byte-lane merges against a reference model, the base-register sizing readback, set-over-clear priority on a flag, and writes to read-only and reserved dwords leaving them unchanged.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int CFG_AW   = 6;   // 64 dwords = 256 bytes
  localparam int ERR_LSB  = 11;  // first sticky error flag in status
  localparam int STAT_INT = 3;   // interrupt-pending status bit

  localparam logic [CFG_AW-1:0] DW_IDENT   = 6'd0;
  localparam logic [CFG_AW-1:0] DW_CMDSTAT = 6'd1;
  localparam logic [CFG_AW-1:0] DW_CLASS   = 6'd2;
  localparam logic [CFG_AW-1:0] DW_MISC    = 6'd3;
  localparam logic [CFG_AW-1:0] DW_BAR0    = 6'd4;

  // expand four byte enables into a 32-bit lane mask
  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  // replace enabled, writable bits of old with new data
  function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
      input logic [31:0] wdata, input logic [3:0] be, input logic [31:0] rw_mask);
    logic [31:0] m;
    m = lane_mask(be) & rw_mask;
    return (old_v & ~m) | (wdata & m);
  endfunction

  // write-one-to-clear on enabled lanes
  function automatic logic [31:0] clear_ones(input logic [31:0] old_v,
      input logic [31:0] wdata, input logic [3:0] be);
    return old_v & ~(wdata & lane_mask(be));
  endfunction
endpackage

// File: rtl/cfg_cmd_stat.sv
module cfg_cmd_stat import cfg_hdr_pkg::*; #(
  parameter int          ERR_W       = 5,
  parameter logic [15:0] CMD_RW_MASK = 16'h0403,
  parameter logic [15:0] CMD_RST     = 16'h0400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  input  logic [ERR_W-1:0] err_evt,
  input  logic             int_pending,
  output logic [31:0]      cmdstat,
  output logic [15:0]      cmd,
  output logic [ERR_W-1:0] err_flags
);
  localparam int ERR_POS = 16 + ERR_LSB;

  logic [15:0]      cmd_q;
  logic [ERR_W-1:0] err_q;
  logic [ERR_W-1:0] err_kept;
  logic [15:0]      stat_w;

  always_comb begin
    err_kept = err_q;
    if (wr_hit)
      err_kept = ERR_W'(clear_ones(32'(err_q) << ERR_POS, wdata, be) >> ERR_POS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_RST;
      err_q <= '0;
    end else begin
      if (wr_hit) cmd_q <= 16'(merge_bytes({16'h0, cmd_q}, wdata, be, {16'h0, CMD_RW_MASK}));
      err_q <= err_kept | err_evt;
    end
  end

  assign stat_w    = (16'(err_q) << ERR_LSB) | (16'(int_pending) << STAT_INT);
  assign cmdstat   = {stat_w, cmd_q};
  assign cmd       = cmd_q;
  assign err_flags = err_q;
endmodule

// File: rtl/cfg_bar.sv
module cfg_bar import cfg_hdr_pkg::*; #(
  parameter int BAR_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] bar
);
  localparam logic [31:0] BAR_RW = 32'hFFFF_FFFF << BAR_LOG2;

  logic [31:0] bar_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bar_q <= '0;
    else if (wr_hit) bar_q <= merge_bytes(bar_q, wdata, be, BAR_RW);
  end

  assign bar = bar_q;
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux import cfg_hdr_pkg::*; (
  input  logic [CFG_AW-1:0] addr,
  input  logic [31:0]       ident_dw,
  input  logic [31:0]       cmdstat_dw,
  input  logic [31:0]       class_dw,
  input  logic [31:0]       misc_dw,
  input  logic [31:0]       bar_dw,
  output logic [31:0]       rd_data
);
  always_comb begin
    case (addr)
      DW_IDENT:   rd_data = ident_dw;
      DW_CMDSTAT: rd_data = cmdstat_dw;
      DW_CLASS:   rd_data = class_dw;
      DW_MISC:    rd_data = misc_dw;
      DW_BAR0:    rd_data = bar_dw;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cfg_hdr_target.sv
module cfg_hdr_target import cfg_hdr_pkg::*; #(
  parameter logic [15:0] VENDOR_ID  = 16'h1D5A,
  parameter logic [15:0] DEVICE_ID  = 16'h7E31,
  parameter logic [23:0] CLASS_CODE = 24'h058000,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter int          BAR_LOG2   = 12,
  parameter int          ERR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_rvalid,
  input  logic [ERR_W-1:0]  err_evt,
  input  logic              int_pending,
  output logic              io_en,
  output logic              mem_en,
  output logic              irq_en,
  output logic [31:0]       mem_base
);
  localparam logic [31:0] MISC_RST  = {8'h00, HDR_TYPE, 16'h0000};
  localparam logic [31:0] MISC_RW   = 32'h0000_FFFF;

  // named internal events
  logic rd_req, wr_req, wr_cmdstat, wr_misc, wr_bar;
  assign rd_req     = cfg_req && !cfg_we;
  assign wr_req     = cfg_req && cfg_we;
  assign wr_cmdstat = wr_req && (cfg_addr == DW_CMDSTAT);
  assign wr_misc    = wr_req && (cfg_addr == DW_MISC);
  assign wr_bar     = wr_req && (cfg_addr == DW_BAR0);

  logic [31:0]      cmdstat_dw, bar_dw, misc_q, rd_mux;
  logic [15:0]      cmd;
  logic [ERR_W-1:0] err_q;

  cfg_cmd_stat #(.ERR_W(ERR_W)) u_cmd_stat (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_cmdstat), .be(cfg_be), .wdata(cfg_wdata),
    .err_evt(err_evt), .int_pending(int_pending), .cmdstat(cmdstat_dw),
    .cmd(cmd), .err_flags(err_q));

  cfg_bar #(.BAR_LOG2(BAR_LOG2)) u_bar (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_bar), .be(cfg_be), .wdata(cfg_wdata),
    .bar(bar_dw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       misc_q <= MISC_RST;
    else if (wr_misc) misc_q <= merge_bytes(misc_q, cfg_wdata, cfg_be, MISC_RW);
  end

  cfg_rd_mux u_rd_mux (
    .addr(cfg_addr), .ident_dw({DEVICE_ID, VENDOR_ID}), .cmdstat_dw(cmdstat_dw),
    .class_dw({CLASS_CODE, REVISION}), .misc_dw(misc_q), .bar_dw(bar_dw),
    .rd_data(rd_mux));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= rd_req;
      if (rd_req) cfg_rdata <= rd_mux;
    end
  end

  assign io_en    = cmd[0];
  assign mem_en   = cmd[1];
  assign irq_en   = !cmd[10];
  assign mem_base = bar_dw;
endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk #(
  parameter logic [15:0] VENDOR_ID = 16'h0,
  parameter logic [15:0] DEVICE_ID = 16'h0,
  parameter int          BAR_LOG2  = 12,
  parameter int          ERR_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             cmd_lo_wr,
  input logic             cmd_hi_wr,
  input logic             stat_hi_wr,
  input logic [5:0]       cfg_addr,
  input logic [31:0]      cfg_rdata,
  input logic             cfg_rvalid,
  input logic             io_en,
  input logic             mem_en,
  input logic             irq_en,
  input logic [ERR_W-1:0] err_evt,
  input logic [ERR_W-1:0] err_q
);
  localparam logic [31:0] LOW_MASK = ~(32'hFFFF_FFFF << BAR_LOG2);

  assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> cfg_rvalid);
  assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !cfg_rvalid);
  assert_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && $past(cfg_addr) == 6'd0) |-> cfg_rdata == {DEVICE_ID, VENDOR_ID});
  assert_decode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_lo_wr |=> ($stable(io_en) && $stable(mem_en)));
  assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_hi_wr |=> $stable(irq_en));
  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> ((err_q & $past(err_evt)) == $past(err_evt)));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_hi_wr |=> ((err_q & $past(err_q)) == $past(err_q)));
  assert_bar_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && $past(cfg_addr) == 6'd4) |-> (cfg_rdata & LOW_MASK) == 32'h0);
  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && $past(cfg_addr) >= 6'd5) |-> cfg_rdata == 32'h0);
endmodule

bind cfg_hdr_target cfg_hdr_chk #(
  .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .BAR_LOG2(BAR_LOG2), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
  .cmd_lo_wr(wr_cmdstat && cfg_be[0]), .cmd_hi_wr(wr_cmdstat && cfg_be[1]),
  .stat_hi_wr(wr_cmdstat && cfg_be[3]), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .cfg_rvalid(cfg_rvalid), .io_en(io_en), .mem_en(mem_en), .irq_en(irq_en),
  .err_evt(err_evt), .err_q(err_q));

// File: tb/cfg_hdr_target_test.sv
`timescale 1ns/1ps
module cfg_hdr_target_test;
  localparam logic [15:0] VID = 16'h1D5A;
  localparam logic [15:0] DID = 16'h7E31;
  localparam logic [23:0] CLS = 24'h058000;
  localparam logic [7:0]  REV = 8'h03;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_req = 1'b0, cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic [4:0]  err_evt = '0;
  logic        int_pending = 1'b0;
  logic        io_en, mem_en, irq_en;
  logic [31:0] mem_base;

  always #2.5 clk = ~clk;

  cfg_hdr_target #(.VENDOR_ID(VID), .DEVICE_ID(DID), .CLASS_CODE(CLS), .REVISION(REV)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .err_evt(err_evt), .int_pending(int_pending), .io_en(io_en), .mem_en(mem_en),
    .irq_en(irq_en), .mem_base(mem_base));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_cmd = 16'h0400;
  logic [4:0]  m_err = '0;
  logic [31:0] m_bar = '0;
  logic [7:0]  m_cls = '0, m_lat = '0;
  logic [31:0] last_rd;

  function automatic logic [31:0] model_read(input logic [5:0] a, input logic ip);
    case (a)
      6'd0: return {DID, VID};
      6'd1: return {m_err, 7'b0, ip, 3'b0, m_cmd};
      6'd2: return {CLS, REV};
      6'd3: return {16'h0000, m_lat, m_cls};
      6'd4: return m_bar;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    if (a == 6'd1) begin
      if (be[0]) m_cmd[7:0]  = d[7:0] & 8'h03;
      if (be[1]) m_cmd[15:8] = d[15:8] & 8'h04;
      if (be[3]) m_err = m_err & ~d[31:27];
    end else if (a == 6'd3) begin
      if (be[0]) m_cls = d[7:0];
      if (be[1]) m_lat = d[15:8];
    end else if (a == 6'd4) begin
      if (be[1]) m_bar[15:12] = d[15:12];
      if (be[2]) m_bar[23:16] = d[23:16];
      if (be[3]) m_bar[31:24] = d[31:24];
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one configuration access; returns at the negedge after the capturing edge
  task automatic op(input bit we, input logic [5:0] a, input logic [3:0] be,
                    input logic [31:0] d, input logic [4:0] ev, input string req);
    logic [31:0] exp;
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = we; cfg_addr = a; cfg_be = be; cfg_wdata = d; err_evt = ev;
    exp = model_read(a, int_pending);
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0; err_evt = '0;
    last_rd = cfg_rdata;
    if (!we) begin
      chk("R2", 32'(cfg_rvalid), 32'd1);
      chk(req, cfg_rdata, exp);
    end else begin
      chk("R2", 32'(cfg_rvalid), 32'd0);
      model_write(a, be, d);
    end
    m_err = m_err | ev;
    chk("R4", {29'd0, irq_en, mem_en, io_en}, {29'd0, !m_cmd[10], m_cmd[1], m_cmd[0]});
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {29'd0, irq_en, mem_en, io_en}, 32'd0);
    op(0, 6'd1, 4'h0, 0, 0, "R1"); chk("R1", last_rd, 32'h0000_0400);
    op(0, 6'd4, 4'h0, 0, 0, "R1"); chk("R1", last_rd, 32'h0);
    // R2 response lasts one cycle
    @(negedge clk); chk("R2", 32'(cfg_rvalid), 32'd0);
    // R3 read-only identity
    op(1, 6'd0, 4'hF, 32'hFFFF_FFFF, 0, "R3");
    op(0, 6'd0, 4'h0, 0, 0, "R3"); chk("R3", last_rd, {DID, VID});
    op(1, 6'd2, 4'hF, 32'h0, 0, "R3");
    op(0, 6'd2, 4'h0, 0, 0, "R3"); chk("R3", last_rd, 32'h0580_0003);
    op(1, 6'd3, 4'hC, 32'hFFFF_FFFF, 0, "R3");
    op(0, 6'd3, 4'h0, 0, 0, "R3"); chk("R3", last_rd & 32'hFFFF_0000, 32'h0);
    // R4 command bits
    op(1, 6'd1, 4'h1, 32'h0000_00FF, 0, "R4");
    chk("R4", {30'd0, mem_en, io_en}, 32'd3);
    op(1, 6'd1, 4'h2, 32'h0000_0000, 0, "R4");
    chk("R4", 32'(irq_en), 32'd1);
    op(0, 6'd1, 4'h0, 0, 0, "R4"); chk("R4", last_rd & 32'hFFFF, 32'h0003);
    // R6 set, keep on zero write, clear one, set beats clear
    op(0, 6'd5, 4'h0, 0, 5'b10101, "R6");
    op(1, 6'd1, 4'h8, 32'h0, 0, "R6");
    op(0, 6'd1, 4'h0, 0, 0, "R6"); chk("R6", last_rd[31:27], 32'h15);
    op(1, 6'd1, 4'h8, 32'h0800_0000, 0, "R6");
    op(0, 6'd1, 4'h0, 0, 0, "R6"); chk("R6", last_rd[31:27], 32'h14);
    op(1, 6'd1, 4'h8, 32'h8000_0000, 5'b10000, "R6");
    op(0, 6'd1, 4'h0, 0, 0, "R6"); chk("R6", last_rd[31:27], 32'h14);
    // R5 byte lanes: command bytes only leave flags; status bytes only leave command
    op(1, 6'd1, 4'h3, 32'hFFFF_0000, 0, "R5");
    op(0, 6'd1, 4'h0, 0, 0, "R5"); chk("R5", last_rd, 32'hA000_0000);
    op(1, 6'd1, 4'hC, 32'h0000_0403, 0, "R5");
    op(0, 6'd1, 4'h0, 0, 0, "R5"); chk("R5", last_rd & 32'hFFFF, 32'h0);
    // R7 interrupt pending level
    int_pending = 1'b1;
    op(0, 6'd1, 4'h0, 0, 0, "R7"); chk("R7", 32'(last_rd[19]), 32'd1);
    int_pending = 1'b0;
    op(0, 6'd1, 4'h0, 0, 0, "R7"); chk("R7", 32'(last_rd[19]), 32'd0);
    // R8 base sizing
    op(1, 6'd4, 4'hF, 32'hFFFF_FFFF, 0, "R8");
    op(0, 6'd4, 4'h0, 0, 0, "R8"); chk("R8", last_rd, 32'hFFFF_F000);
    op(1, 6'd4, 4'h6, 32'h1234_5678, 0, "R8");
    op(0, 6'd4, 4'h0, 0, 0, "R8"); chk("R8", last_rd, 32'hFF34_5000);
    chk("R8", mem_base, 32'hFF34_5000);
    // R9 cache line / latency
    op(1, 6'd3, 4'h3, 32'hAAAA_9C10, 0, "R9");
    op(0, 6'd3, 4'h0, 0, 0, "R9"); chk("R9", last_rd, 32'h0000_9C10);
    // R10 reserved area
    op(1, 6'd20, 4'hF, 32'hFFFF_FFFF, 0, "R10");
    op(0, 6'd20, 4'h0, 0, 0, "R10"); chk("R10", last_rd, 32'h0);
    op(1, 6'd63, 4'hF, 32'hFFFF_FFFF, 0, "R10");
    op(0, 6'd63, 4'h0, 0, 0, "R10"); chk("R10", last_rd, 32'h0);
    op(0, 6'd5, 4'h0, 0, 0, "R10"); chk("R10", last_rd, 32'h0);
    // random mix against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [5:0] a;
      logic [4:0] ev;
      int sel = $urandom % 8;
      a  = (sel < 5) ? 6'(sel) : 6'($urandom % 64);
      ev = (($urandom % 4) == 0) ? 5'($urandom) : 5'd0;
      int_pending = 1'($urandom);
      op(1'($urandom), a, 4'($urandom), $urandom, ev, "R5");
    end
    done = 1;
    report();
    $finish;
  end
endmodule